// File: doc/BRIEF.md
# Data Access Fault Detector

This block inspects every load or store address presented by a processor's memory stage and decides whether the access breaks one of two rules: the address must be aligned to the access size, and it must fall inside the window set by a pair of stack limit registers whenever stack checking is on. A detected fault writes the faulting address and a packed status word into two capture registers. The block can also emit a one-cycle exception request.

Alignment is tested by ANDing the address with a size mask: 0 for a byte, 1 for a halfword, 3 for a word. A misaligned access always updates the capture registers. It raises the request only when the machine-status exception-enable input is high. A stack-window violation updates the capture registers and raises the request every time. When both rules fail on the same access, the alignment fault wins.

Top module: `dacc_fault_chk`

## Requirements
- R1: After reset the captured address, the captured status and the exception request are all zero.
- R2: A valid access is misaligned when (address & size mask) != 0. The size mask is 0 for byte, 1 for halfword and 3 for word. A misaligned access loads the captured address with the access address on the next clock edge.
- R3: For a misaligned access the captured status is written as follows: bits 4:0 = 1 (unaligned cause), bit 10 = write flag, bits 9:5 = register number, bit 11 = 1 exactly when the size mask is 3, and every other bit 0.
- R4: A misaligned access raises the exception request only when exception-enable is 1. When exception-enable is 0 the capture registers are still written, and no request is raised.
- R5: With stack checking enabled, an aligned valid access whose address is below the low limit or above the high limit is a stack violation. Addresses equal to either limit do not violate.
- R6: A stack violation loads the captured address with the access address and loads the captured status with 7 in bits 4:0 and zeros elsewhere. It raises the request whatever exception-enable is.
- R7: If an access is both misaligned and outside the stack window, only the alignment fault is recorded.
- R8: The exception request is high for exactly the one cycle after the faulting access and is written on the same edge as the capture registers. Accesses with no fault, with valid low, or with stack checking off (when aligned) leave both capture registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_size_mask | input | 2 | Alignment mask: 0 byte, 1 half, 3 word |
| acc_write | input | 1 | 1 for store, 0 for load |
| acc_reg | input | 5 | Destination/source register number |
| stk_chk_en | input | 1 | Enables the stack-window check |
| stk_lo | input | 32 | Lowest allowed address (inclusive) |
| stk_hi | input | 32 | Highest allowed address (inclusive) |
| exc_enable | input | 1 | Machine-status exception-enable bit |
| fault_addr | output | 32 | Captured faulting address |
| fault_status | output | 32 | Captured fault status word |
| exc_req | output | 1 | One-cycle exception request |

## Verification
The assertions assume that the size mask only ever takes the values 0, 1 or 3. They also assume that the request inputs and the stack limits are stable around each rising edge, so each access is judged on one clean set of values. The bench drives mask 2 nowhere, and it changes inputs only on the falling clock edge. Stack limits are always programmed with low at or below high, so the inclusive window is never empty, although the logic does not depend on that.

// File: rtl/dacc_fault_pkg.sv
package dacc_fault_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned STAT_W  = 32;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned MASK_W  = 2;
  localparam int unsigned CAUSE_W = 5;
  localparam int unsigned REG_LSB = 5;
  localparam int unsigned WR_BIT  = 10;
  localparam int unsigned WORD_BIT = 11;

  localparam logic [CAUSE_W-1:0] CAUSE_UNALIGNED = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_STACK     = 5'd7;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ALIGN = 2'd1,
    FLT_STACK = 2'd2
  } fault_kind_e;
endpackage

// File: rtl/dacc_align_chk.sv
module dacc_align_chk
  import dacc_fault_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned MW = MASK_W
) (
  input  logic [AW-1:0] addr,
  input  logic [MW-1:0] size_mask,
  output logic          misaligned,
  output logic          is_word
);
  localparam logic [MW-1:0] WORD_MASK = {MW{1'b1}};

  always_comb begin
    misaligned = |(addr[MW-1:0] & size_mask);
    is_word    = (size_mask == WORD_MASK);
  end
endmodule

// File: rtl/dacc_stack_chk.sv
module dacc_stack_chk
  import dacc_fault_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          enable,
  output logic          violation
);
  logic below, above;
  always_comb begin
    below     = (addr < lo);
    above     = (addr > hi);
    violation = enable & (below | above);
  end
endmodule

// File: rtl/dacc_status_fmt.sv
module dacc_status_fmt
  import dacc_fault_pkg::*;
(
  input  fault_kind_e       kind,
  input  logic              write_flag,
  input  logic [REG_W-1:0]  reg_num,
  input  logic              is_word,
  output logic [STAT_W-1:0] status
);
  always_comb begin
    status = '0;
    unique case (kind)
      FLT_ALIGN: begin
        status[CAUSE_W-1:0]             = CAUSE_UNALIGNED;
        status[REG_LSB +: REG_W]        = reg_num;
        status[WR_BIT]                  = write_flag;
        status[WORD_BIT]                = is_word;
      end
      FLT_STACK: status[CAUSE_W-1:0]    = CAUSE_STACK;
      default:   status                 = '0;
    endcase
  end
endmodule

// File: rtl/dacc_fault_chk.sv
module dacc_fault_chk
  import dacc_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [MASK_W-1:0] acc_size_mask,
  input  logic              acc_write,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic              stk_chk_en,
  input  logic [ADDR_W-1:0] stk_lo,
  input  logic [ADDR_W-1:0] stk_hi,
  input  logic              exc_enable,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [STAT_W-1:0] fault_status,
  output logic              exc_req
);
  logic misaligned, is_word, stk_viol;
  fault_kind_e kind;
  logic [STAT_W-1:0] status_nxt;
  logic capture_en, req_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [STAT_W-1:0] stat_nxt;

  dacc_align_chk #(.AW(ADDR_W), .MW(MASK_W)) u_align (
    .addr(acc_addr), .size_mask(acc_size_mask),
    .misaligned(misaligned), .is_word(is_word)
  );

  dacc_stack_chk #(.AW(ADDR_W)) u_stack (
    .addr(acc_addr), .lo(stk_lo), .hi(stk_hi),
    .enable(stk_chk_en), .violation(stk_viol)
  );

  // Alignment fault has priority over the stack window.
  always_comb begin
    kind = FLT_NONE;
    if (acc_valid) begin
      if (misaligned)    kind = FLT_ALIGN;
      else if (stk_viol) kind = FLT_STACK;
    end
  end

  dacc_status_fmt u_fmt (
    .kind(kind), .write_flag(acc_write), .reg_num(acc_reg),
    .is_word(is_word), .status(status_nxt)
  );

  always_comb begin
    capture_en = (kind != FLT_NONE);
    req_nxt    = (kind == FLT_STACK) | ((kind == FLT_ALIGN) & exc_enable);
    addr_nxt   = capture_en ? acc_addr : fault_addr;
    stat_nxt   = capture_en ? status_nxt : fault_status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr   <= '0;
      fault_status <= '0;
      exc_req      <= 1'b0;
    end else begin
      fault_addr   <= addr_nxt;
      fault_status <= stat_nxt;
      exc_req      <= req_nxt;
    end
  end

  // R4: disabled alignment fault raises no request
  p_align_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr[1:0] & acc_size_mask) != 0 && !exc_enable) |=> !exc_req);

  // R6: stack violation always requests
  p_stack_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr[1:0] & acc_size_mask) == 0 && stk_chk_en &&
     (acc_addr < stk_lo || acc_addr > stk_hi)) |=> (exc_req && fault_status == 32'd7));

  // R2: misaligned address captured
  p_align_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr[1:0] & acc_size_mask) != 0) |=> fault_addr == $past(acc_addr));

  // R8: no valid access keeps captures stable and request low
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> ($stable(fault_addr) && $stable(fault_status) && !exc_req));

  // R7: alignment wins over stack
  p_align_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr[1:0] & acc_size_mask) != 0) |=> fault_status[4:0] == 5'd1);
endmodule

// File: tb/dacc_fault_chk_bench.sv
module dacc_fault_chk_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_write, stk_chk_en, exc_enable;
  logic [31:0] acc_addr, stk_lo, stk_hi;
  logic [1:0] acc_size_mask;
  logic [4:0] acc_reg;
  logic [31:0] fault_addr, fault_status;
  logic exc_req;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dacc_fault_chk u_dacc_fault_chk (.*);

  // vector: valid, addr, mask, wr, reg, sen, en, exp_req, exp_upd, exp_stat
  typedef struct packed {
    logic        v;
    logic [31:0] a;
    logic [1:0]  m;
    logic        w;
    logic [4:0]  r;
    logic        s;
    logic        e;
    logic        xr;
    logic        xu;
    logic [31:0] xs;
  } vec_t;
  localparam int NV = 12;
  // window lo=0x1000 hi=0x1FFF
  localparam vec_t VT [NV] = '{
    '{1,32'h0000_1001,2'd1,1,5'd3, 0,1,1,1,32'h0000_0461},  // R3 half store
    '{1,32'h0000_1002,2'd3,0,5'd31,0,1,1,1,32'h0000_0BE1},  // R3 word load bit11
    '{1,32'h0000_1003,2'd0,1,5'd4, 0,1,0,0,32'h0},          // byte never misaligned
    '{1,32'h0000_1006,2'd1,0,5'd2, 1,1,0,0,32'h0},          // aligned inside window
    '{1,32'h0000_1003,2'd3,1,5'd9, 0,0,0,1,32'h0000_0D21},  // R4 masked still captures
    '{1,32'h0000_0FFF,2'd0,0,5'd1, 1,1,1,1,32'h7},          // R5 below
    '{1,32'h0000_2000,2'd0,0,5'd1, 1,0,1,1,32'h7},          // R6 above, enable off
    '{1,32'h0000_1000,2'd0,0,5'd1, 1,1,0,0,32'h0},          // R5 lo inclusive
    '{1,32'h0000_1FFF,2'd0,0,5'd1, 1,1,0,0,32'h0},          // R5 hi inclusive
    '{1,32'h0000_0001,2'd1,1,5'd7, 1,1,1,1,32'h0000_04E1},  // R7 priority
    '{1,32'h0000_0004,2'd3,0,5'd7, 0,1,0,0,32'h0},          // R8 stk off no fault
    '{0,32'h0000_0003,2'd3,1,5'd7, 1,1,0,0,32'h0}           // R8 invalid ignored
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    acc_valid = t.v; acc_addr = t.a; acc_size_mask = t.m; acc_write = t.w;
    acc_reg = t.r; stk_chk_en = t.s; exc_enable = t.e;
  endtask

  initial begin
    #1500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] ea, es;
    rst_n = 1'b0; acc_valid = 0; acc_addr = 0; acc_size_mask = 0; acc_write = 0;
    acc_reg = 0; stk_chk_en = 0; exc_enable = 0; stk_lo = 32'h1000; stk_hi = 32'h1FFF;
    repeat (2) @(negedge clk);
    chk("R1 addr", fault_addr, 0);
    chk("R1 status", fault_status, 0);
    chk("R1 req", {31'b0, exc_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ea = 0; es = 0;
    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      @(negedge clk);
      if (VT[i].xu) begin ea = VT[i].a; es = VT[i].xs; end
      chk($sformatf("R8/R2 addr v%0d", i), fault_addr, ea);
      chk($sformatf("R3/R6 status v%0d", i), fault_status, es);
      chk($sformatf("R4/R8 req v%0d", i), {31'b0, exc_req}, {31'b0, VT[i].xr});
    end
    // R8: pulse lasts one cycle for a held-then-dropped fault
    drive('{1,32'h0000_0005,2'd1,0,5'd0,0,1,0,0,32'h0});
    @(negedge clk);
    chk("R8 pulse on", {31'b0, exc_req}, 1);
    acc_valid = 0;
    @(negedge clk);
    chk("R8 pulse off", {31'b0, exc_req}, 0);
    chk("R2 addr kept", fault_addr, 32'h5);
    // R1: reset mid-run clears
    rst_n = 0;
    @(negedge clk);
    chk("R1 re-reset", fault_status, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule